// File: doc/BRIEF.md
# Table-Weighted Four-Tap Cubic Interpolator

This block turns four neighbouring unsigned pixel samples and a fractional sample position into one interpolated output pixel. The four tap weights are not computed in logic. They are read from an on-chip coefficient table that is indexed by the fractional position. Each table entry holds one signed weight per tap, so the same hardware can run any four-tap kernel: cubic, sharpened, linear or nearest. The kernel is whatever software has loaded into the table.

The table is loaded through a plain write port. Each 32-bit write word carries a pair of weights. The datapath accepts one lookup per clock and delivers a rounded, clamped pixel a fixed three cycles later. Typical use is as the inner kernel of a scaler or warper. In that setting an address generator supplies the four neighbours and the sub-pixel fraction of each output sample.

Top module: `cubic_lut_interp`

## Requirements
- R1: Every cycle with `in_valid` high produces exactly one cycle of `out_valid` high three clock edges later; `out_valid` is low in every other cycle; lookups may arrive back to back on consecutive cycles.
- R2: The output equals the sum over the four taps of pixel times weight, plus 128, arithmetically shifted right by 8, before clamping; tap k uses pixel `in_pix[8k+7:8k]` and weight k of the addressed entry.
- R3: When the rounded sum is negative the output pixel is 0.
- R4: When the rounded sum exceeds 255 the output pixel is 255; a rounded sum of exactly 255 passes unchanged.
- R5: `in_frac` selects one of 1024 independent table entries; entries 0 and 1023 are both reachable and a write to one entry changes no other entry.
- R6: A write with `wr_addr[0]`=0 loads weights 0 and 1 of entry `wr_addr[10:1]`; `wr_addr[0]`=1 loads weights 2 and 3. The first weight of the pair comes from `wr_data[13:0]` and the second from `wr_data[29:16]`. Bits 15:14 and 31:30 are ignored, and the other pair of the entry is left unchanged.
- R7: Weights are 14-bit two's-complement values in which 256 means unity; negative weights subtract from the sum.
- R8: A lookup in the same cycle as a write to the same entry uses the weights held before that write; the next lookup sees the new weights.
- R9: After reset `out_valid` is 0 and `out_pix` is 0; in cycles without an output the pixel keeps its last delivered value.
- R10: Rounding is half-up: a sum of 128 (one half) produces 1 and a sum of 127 produces 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Table write strobe |
| wr_addr | input | 11 | Bit 0 selects the weight pair, bits 10:1 the entry |
| wr_data | input | 32 | Two weights, at bits 13:0 and 29:16 |
| in_valid | input | 1 | Lookup strobe |
| in_frac | input | 10 | Fractional position, used as the table index |
| in_pix | input | 32 | Four unsigned pixels, tap k at bits 8k+7:8k |
| out_valid | output | 1 | Output pixel strobe |
| out_pix | output | 8 | Interpolated, clamped pixel |

## Verification
A corrupted table word shows up only in lookups of that one fraction, three cycles after the lookup. The bench therefore loads every entry with a distinct kernel and probes the extreme indices and individual weight pairs. A broken strobe chain shows up as a missing or extra `out_valid`, or as a `out_pix` that drifts between outputs. That symptom appears in the same third cycle, and every idle cycle is compared against the last delivered pixel. A read port that forwards the write data, or that reads a stale entry, differs from the correct design only in the exact collision cycle. For that reason the write and the lookup are issued together there, and again one cycle later.

// File: rtl/cli_pkg.sv
package cli_pkg;
   // Layout of one table write word: a pair of weights, the second at a fixed offset.
   localparam int unsigned WR_WORD_W      = 32;
   localparam int unsigned WR_HI_OFS      = 16;
   localparam int unsigned COEFS_PER_WORD = 2;
endpackage

// File: rtl/cli_coef_bank.sv
module cli_coef_bank #(
   parameter int unsigned ADDR_W = 10,
   parameter int unsigned DATA_W = 28
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data
);
   localparam int unsigned DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] mem [DEPTH];
   logic [DATA_W-1:0] peek;

   assign peek = mem[rd_addr];

   always_ff @(posedge clk) begin
      if (wr_en) mem[wr_addr] <= wr_data;
   end

   // Read register samples the array before this edge's write lands.
   always_ff @(posedge clk) begin
      if (rd_en) rd_data <= mem[rd_addr];
   end

   assert_write_lands_R6: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (mem[$past(wr_addr)] == $past(wr_data)));

   assert_old_on_collide_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && wr_en && (rd_addr == wr_addr)) |=> (rd_data == $past(peek)));
endmodule

// File: rtl/cli_mac.sv
module cli_mac #(
   parameter int unsigned TAPS      = 4,
   parameter int unsigned PIX_W     = 8,
   parameter int unsigned COEF_W    = 14,
   parameter int unsigned ONE_SHIFT = 8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    in_valid,
   input  logic [TAPS*PIX_W-1:0]   pix,
   input  logic [TAPS*COEF_W-1:0]  coef,
   output logic                    out_valid,
   output logic [PIX_W-1:0]        out_pix
);
   localparam int unsigned PROD_W  = PIX_W + 1 + COEF_W;
   localparam int unsigned ACC_W   = PROD_W + $clog2(TAPS);
   localparam int unsigned RND_W   = ACC_W + 1;
   localparam int          HALF    = 1 << (ONE_SHIFT - 1);
   localparam int          PIX_MAX = (1 << PIX_W) - 1;
   localparam logic signed [RND_W-1:0] MAX_S = RND_W'(PIX_MAX);

   logic signed [PROD_W-1:0] prod_w [TAPS];
   logic                     mid_valid;
   logic signed [RND_W-1:0]  acc;
   logic signed [RND_W-1:0]  rounded;
   logic [PIX_W-1:0]         clamped;

   for (genvar t = 0; t < TAPS; t++) begin : g_tap
      logic signed [PROD_W-1:0] prod_q;
      always_ff @(posedge clk) begin
         if (in_valid)
            prod_q <= $signed({1'b0, pix[t*PIX_W +: PIX_W]}) * $signed(coef[t*COEF_W +: COEF_W]);
      end
      assign prod_w[t] = prod_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mid_valid <= 1'b0;
      else        mid_valid <= in_valid;
   end

   always_comb begin
      acc = '0;
      for (int t = 0; t < TAPS; t++) acc = acc + RND_W'(prod_w[t]);
      rounded = (acc + RND_W'(HALF)) >>> ONE_SHIFT;
      if (rounded[RND_W-1])     clamped = '0;
      else if (rounded > MAX_S) clamped = PIX_W'(PIX_MAX);
      else                      clamped = rounded[PIX_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_pix   <= '0;
      end else begin
         out_valid <= mid_valid;
         if (mid_valid) out_pix <= clamped;
      end
   end

   assert_floor_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (mid_valid && rounded[RND_W-1]) |=> (out_valid && (out_pix == '0)));

   assert_ceil_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (mid_valid && !rounded[RND_W-1] && (rounded > MAX_S)) |=> (out_pix == PIX_W'(PIX_MAX)));

   assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !mid_valid |=> (!out_valid && $stable(out_pix)));
endmodule

// File: rtl/cubic_lut_interp.sv
module cubic_lut_interp #(
   parameter int unsigned PIX_W     = 8,
   parameter int unsigned FRAC_W    = 10,
   parameter int unsigned COEF_W    = 14,
   parameter int unsigned TAPS      = 4,
   parameter int unsigned ONE_SHIFT = 8
) (
   input  logic                                          clk,
   input  logic                                          rst_n,
   input  logic                                          wr_en,
   input  logic [FRAC_W+$clog2(TAPS/cli_pkg::COEFS_PER_WORD)-1:0] wr_addr,
   input  logic [cli_pkg::WR_WORD_W-1:0]                 wr_data,
   input  logic                                          in_valid,
   input  logic [FRAC_W-1:0]                             in_frac,
   input  logic [TAPS*PIX_W-1:0]                         in_pix,
   output logic                                          out_valid,
   output logic [PIX_W-1:0]                              out_pix
);
   import cli_pkg::*;

   localparam int unsigned BANKS  = TAPS / COEFS_PER_WORD;
   localparam int unsigned SEL_W  = $clog2(BANKS);
   localparam int unsigned BANK_W = COEFS_PER_WORD * COEF_W;

   if (TAPS < 4 || (TAPS & (TAPS - 1)) != 0) begin : g_bad_taps
      $error("TAPS must be a power of two of at least 4");
   end
   if (COEF_W > WR_HI_OFS) begin : g_bad_coef
      $error("COEF_W does not fit in half a write word");
   end
   if (ONE_SHIFT < 1 || ONE_SHIFT >= COEF_W) begin : g_bad_shift
      $error("ONE_SHIFT must lie between 1 and COEF_W-1");
   end

   logic [TAPS*COEF_W-1:0] coef_flat;
   logic [TAPS*PIX_W-1:0]  s1_pix;
   logic                   s1_valid;
   logic                   unused_wr_pad;

   assign unused_wr_pad = ^wr_data;

   for (genvar b = 0; b < BANKS; b++) begin : g_bank
      logic              bank_we;
      logic [BANK_W-1:0] bank_wdata;

      assign bank_we = wr_en && (wr_addr[SEL_W-1:0] == SEL_W'(b));
      for (genvar l = 0; l < COEFS_PER_WORD; l++) begin : g_lane
         assign bank_wdata[l*COEF_W +: COEF_W] = wr_data[l*WR_HI_OFS +: COEF_W];
      end

      cli_coef_bank #(.ADDR_W(FRAC_W), .DATA_W(BANK_W)) u_bank (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr_en   (bank_we),
         .wr_addr (wr_addr[SEL_W +: FRAC_W]),
         .wr_data (bank_wdata),
         .rd_en   (in_valid),
         .rd_addr (in_frac),
         .rd_data (coef_flat[b*BANK_W +: BANK_W])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) s1_valid <= 1'b0;
      else        s1_valid <= in_valid;
   end

   always_ff @(posedge clk) begin
      if (in_valid) s1_pix <= in_pix;
   end

   cli_mac #(.TAPS(TAPS), .PIX_W(PIX_W), .COEF_W(COEF_W), .ONE_SHIFT(ONE_SHIFT)) u_mac (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (s1_valid),
      .pix       (s1_pix),
      .coef      (coef_flat),
      .out_valid (out_valid),
      .out_pix   (out_pix)
   );

   assert_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> ##2 out_valid);

   assert_no_spurious_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> ##2 !out_valid);
endmodule

// File: tb/sim_cubic_lut_interp.sv
`timescale 1ns/1ps
module sim_cubic_lut_interp;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [10:0] wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic        in_valid = 1'b0;
   logic [9:0]  in_frac = '0;
   logic [31:0] in_pix = '0;
   logic        out_valid;
   logic [7:0]  out_pix;

   int    errors = 0;
   int    checks = 0;
   string cur_tag = "R2";
   int    mdl [1024][4];
   bit    d1_v, d2_v;
   int    d1_p, d2_p;
   string d1_t, d2_t;
   int    last_pix = 0;
   int    lcg = 12345;

   always #10 clk = ~clk;

   cubic_lut_interp u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .in_valid(in_valid), .in_frac(in_frac), .in_pix(in_pix),
      .out_valid(out_valid), .out_pix(out_pix)
   );

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic int predict(input int f, input logic [31:0] px);
      int acc = 0;
      int r;
      for (int k = 0; k < 4; k++) acc += int'(px[k*8 +: 8]) * mdl[f][k];
      r = (acc + 128) >>> 8;
      if (r < 0) r = 0;
      if (r > 255) r = 255;
      return r;
   endfunction

   function automatic int rnd();
      lcg = lcg * 1103515245 + 12345;
      return (lcg >>> 8) & 32'h00FF_FFFF;
   endfunction

   // Scoreboard: predicts each lookup from its own table copy, then applies writes (R8 order).
   always begin
      @(posedge clk);
      #2;
      if (!rst_n) begin
         d1_v = 0; d2_v = 0; last_pix = 0;
      end else begin
         check(out_valid == d2_v, "R1 strobe", int'(out_valid), int'(d2_v));
         if (d2_v) begin
            check(int'(out_pix) == d2_p, d2_t, int'(out_pix), d2_p);
            last_pix = d2_p;
         end else begin
            check(int'(out_pix) == last_pix, "R9 hold", int'(out_pix), last_pix);
         end
         d2_v = d1_v; d2_p = d1_p; d2_t = d1_t;
         d1_v = in_valid; d1_t = cur_tag;
         if (in_valid) d1_p = predict(int'(in_frac), in_pix);
         if (wr_en) begin
            mdl[wr_addr[10:1]][2*wr_addr[0]]     = int'($signed(wr_data[13:0]));
            mdl[wr_addr[10:1]][2*wr_addr[0] + 1] = int'($signed(wr_data[29:16]));
         end
      end
   end

   task automatic idle(input int n);
      repeat (n) begin
         @(negedge clk);
         wr_en = 0; in_valid = 0;
      end
   endtask

   task automatic wr(input int e, input int half, input int ca, input int cb);
      @(negedge clk);
      in_valid = 0; wr_en = 1;
      wr_addr = {e[9:0], half[0]};
      wr_data = {2'b11, cb[13:0], 2'b10, ca[13:0]};
   endtask

   task automatic look(input int f, input int p0, input int p1, input int p2, input int p3);
      @(negedge clk);
      wr_en = 0; in_valid = 1; in_frac = f[9:0];
      in_pix = {p3[7:0], p2[7:0], p1[7:0], p0[7:0]};
   endtask

   task automatic set_entry(input int e, input int c0, input int c1, input int c2, input int c3);
      wr(e, 0, c0, c1);
      wr(e, 1, c2, c3);
   endtask

   task automatic t_reset();
      rst_n = 0;
      repeat (4) @(negedge clk);
      check(out_valid == 0, "R9 reset valid", int'(out_valid), 0);
      check(out_pix == 0, "R9 reset pix", int'(out_pix), 0);
      rst_n = 1;
      idle(3);
      check(out_valid == 0 && out_pix == 0, "R9 after reset", int'(out_pix), 0);
   endtask

   task automatic t_load();
      for (int e = 0; e < 1024; e++) begin
         if (e % 5 == 0) set_entry(e, -(e & 31), 256 - (e >> 2), e >> 2, -(e & 15));
         else            set_entry(e, 0, 256 - (e >> 2), e >> 2, 0);
      end
      idle(3);
      cur_tag = "R5 index";
      look(0, 11, 22, 33, 44);
      look(1023, 11, 22, 33, 44);
      look(512, 90, 180, 60, 30);
      look(515, 90, 180, 60, 30);
      look(1, 255, 0, 255, 0);
      idle(4);
   endtask

   task automatic t_formula();
      cur_tag = "R2 weighted sum";
      set_entry(100, 0, 256, 0, 0);
      set_entry(101, 0, 128, 128, 0);
      look(100, 10, 77, 200, 3);
      look(101, 5, 100, 50, 9);
      idle(4);
      cur_tag = "R7 signed weights";
      set_entry(102, -32, 160, 160, -32);
      look(102, 100, 100, 100, 100);
      look(102, 0, 200, 200, 0);
      look(102, 255, 10, 10, 255);
      idle(4);
   endtask

   task automatic t_round();
      cur_tag = "R10 round";
      set_entry(200, 1, 0, 0, 0);
      set_entry(202, -1, 256, 0, 0);
      look(200, 128, 0, 0, 0);
      look(200, 127, 0, 0, 0);
      look(202, 129, 5, 0, 0);
      idle(4);
   endtask

   task automatic t_clamp();
      cur_tag = "R3 floor";
      set_entry(300, -256, 0, 0, 0);
      set_entry(301, -256, 256, 0, 0);
      look(300, 255, 0, 0, 0);
      look(301, 200, 100, 0, 0);
      look(301, 100, 200, 0, 0);
      idle(4);
      cur_tag = "R4 ceiling";
      set_entry(400, 256, 256, 0, 0);
      look(400, 200, 200, 0, 0);
      look(400, 128, 127, 0, 0);
      look(400, 128, 128, 0, 0);
      idle(4);
   endtask

   task automatic t_pair();
      cur_tag = "R6 pair layout";
      set_entry(500, 0, 0, 0, 0);
      wr(500, 1, 256, 0);
      idle(1);
      look(500, 7, 21, 99, 150);
      idle(4);
      wr(500, 0, 0, 256);
      idle(1);
      look(500, 7, 21, 99, 150);
      look(501, 7, 21, 99, 150);
      idle(4);
   endtask

   task automatic t_collide();
      cur_tag = "R8 collision";
      set_entry(600, 0, 256, 0, 0);
      idle(1);
      @(negedge clk);
      wr_en = 1; wr_addr = {10'd600, 1'b0}; wr_data = {2'b00, 14'd0, 2'b00, 14'd256};
      in_valid = 1; in_frac = 10'd600; in_pix = {8'd4, 8'd3, 8'd33, 8'd9};
      look(600, 9, 33, 3, 4);
      idle(4);
   endtask

   task automatic t_stream();
      cur_tag = "R1 stream";
      for (int i = 0; i < 40; i++) begin
         look(rnd() & 1023, rnd() & 255, rnd() & 255, rnd() & 255, rnd() & 255);
      end
      for (int i = 0; i < 20; i++) begin
         look(rnd() & 1023, rnd() & 255, rnd() & 255, rnd() & 255, rnd() & 255);
         idle(1 + (i % 3));
      end
      idle(5);
   endtask

   initial begin
      for (int e = 0; e < 1024; e++)
         for (int k = 0; k < 4; k++) mdl[e][k] = 0;
      t_reset();
      t_load();
      t_formula();
      t_round();
      t_clamp();
      t_pair();
      t_collide();
      t_stream();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #3000000;
      errors++;
      checks++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule